// File: doc/BRIEF.md
# Line Transceiver Diagnostic Control and Loopback Router

This block keeps an 8-bit diagnostic control word for a line transceiver and applies it to the transceiver's serial data paths. Once per frame a control-channel byte arrives. Only bytes whose two low select bits carry the diagnostic code are stored. From the stored word the block drives three things: a four-way loopback router sitting between the system-side and line-side serial paths, three single-bit test controls, and a default-mode indication.

Unless a retain input is held high, a frame pulse wipes the stored word. Diagnostics therefore stay active only while software rewrites the word every frame. A loopback request that the current master/slave role forbids is refused: the router stays on the normal path and a sticky flag records the refusal. When the upper nibble of the stored word is all ones, every individual field is ignored. The block then waits for a preset code in the low five bits of a later control byte. All control outputs are registered. The data paths pass through multiplexers that are steered by those registered controls.

Top module: `diag_ctl`

## Requirements
- R1: A byte presented with `cb_vld_i`=1 is stored only when its bit 0 is 0 and its bit 1 is 1. Any other byte leaves the stored word unchanged.
- R2: Stored bits {3,2} select the route. 00 is normal. 10 returns `sys_in_i` on `sys_out_o`. 01 feeds `core_line_i` into `core_line_o`. 11 feeds `core_sys_i` into `core_sys_o`. Every path not named by the selected route passes straight through.
- R3: Stored bit 4 drives `fun_o`.
- R4: `swap_o` equals stored bit 5 AND `master_i`, where `master_i`=1 means master role.
- R5: Stored bit 6 drives `dlo_o`. While `dlo_o` is 1, `line_out_o` is held at the idle level; otherwise it carries `core_line_i`.
- R6: A `frame_i` pulse with `retain_i`=0 clears the stored word to 0. With `retain_i`=1 the word is kept.
- R7: A valid write in the same cycle as a clearing frame pulse wins, so the written value is stored.
- R8: Route 01 is refused in slave role and route 11 is refused in master role. A refused route falls back to normal and sets `reject_o`, which stays 1 until reset.
- R9: When stored bits 7..4 are all 1, `dflt_o`=1 and `fun_o`, `swap_o`, `dlo_o` are 0 with the route normal. A later valid byte with low five bits 01111 sets `preset_o`=01 (80 kbit/s). Low five bits 11111 sets `preset_o`=10 (160 kbit/s). Outside default mode `preset_o` is 00.
- R10: Bit 7 reads back as 0 on `diag_o` and has no individual control effect.
- R11: Control outputs and `diag_o` change on the same clock edge that stores or clears the word, and never between edges.
- R12: During reset every control output and `diag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cb_vld_i | input | 1 | Control byte valid this cycle |
| cb_data_i | input | 8 | Received control byte |
| frame_i | input | 1 | Frame pulse |
| retain_i | input | 1 | 1 keeps the diagnostic word across frames |
| master_i | input | 1 | 1 = master role, 0 = slave role |
| sys_in_i | input | LANES | System-side serial input pin |
| sys_out_o | output | LANES | System-side serial output pin |
| core_sys_i | input | LANES | Core data headed to the system output |
| core_sys_o | output | LANES | System input as seen by the core |
| line_in_i | input | LANES | Line-side receive input |
| core_line_o | output | LANES | Line receive data as seen by the core |
| core_line_i | input | LANES | Core data headed to the line output |
| line_out_o | output | LANES | Line-side transmit output |
| diag_o | output | 8 | Stored diagnostic word, bit 7 read as 0 |
| fun_o | output | 1 | Force loss of synchronisation |
| swap_o | output | 1 | Interchange scrambler/descrambler polynomials |
| dlo_o | output | 1 | Line output held at idle level |
| reject_o | output | 1 | Sticky: a forbidden loopback was requested |
| dflt_o | output | 1 | Default mode active |
| preset_o | output | 2 | Preset chosen in default mode: 00 none, 01 low rate, 10 high rate |

## Verification
Most internal state of this block reaches `diag_o` or the route within one clock. A missed clear, a lost write or a wrong priority between the two therefore shows up as a `diag_o` mismatch on the very next edge. Route-decoding faults only surface when the data lanes differ from each other, so the lanes carry fresh random values on every cycle. Errors in role gating and in the default-mode flags surface only under the matching combination of `master_i` and the stored nibble, and the sequences drive each such combination. A lost sticky reject stays hidden until a later write puts a legal route in place, which is why the refused-route scenarios are followed by legal writes.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int CB_W          = 8;
    localparam int SEL_LO_BIT    = 0;
    localparam int SEL_HI_BIT    = 1;
    localparam int ROUTE_LO_BIT  = 2;
    localparam int ROUTE_HI_BIT  = 3;
    localparam int FUN_BIT       = 4;
    localparam int SWAP_BIT      = 5;
    localparam int DLO_BIT       = 6;
    localparam int RSV_BIT       = 7;
    localparam int NIB_LO        = 4;
    localparam int PRESET_W      = 5;
    localparam logic [PRESET_W-1:0] PRESET_LOW_CODE  = 5'b01111;
    localparam logic [PRESET_W-1:0] PRESET_HIGH_CODE = 5'b11111;

    // value is {bit3, bit2} of the stored word
    typedef enum logic [1:0] {
        LB_NORMAL   = 2'b00,
        LB_LINE     = 2'b01,
        LB_SYS_ECHO = 2'b10,
        LB_REMOTE   = 2'b11
    } loop_e;

    typedef enum logic [1:0] {
        PRE_NONE = 2'b00,
        PRE_LOW  = 2'b01,
        PRE_HIGH = 2'b10
    } preset_e;

    typedef struct packed {
        logic [CB_W-1:0] dreg;
        preset_e         preset;
        loop_e           loop;
        logic            fun;
        logic            swap;
        logic            dlo;
        logic            reject;
        logic            dflt;
    } diag_state_t;

endpackage

// File: rtl/diag_wr_dec.sv
module diag_wr_dec
    import diag_pkg::*;
(
    input  logic            cb_vld,
    input  logic [CB_W-1:0] cb_data,
    input  logic            frame,
    input  logic            retain,
    input  logic [CB_W-1:0] dreg_cur,
    output logic            wr_en,
    output logic [CB_W-1:0] dreg_next,
    output logic            hit_low,
    output logic            hit_high
);

    logic clr_en;

    always_comb begin
        wr_en  = cb_vld && !cb_data[SEL_LO_BIT] && cb_data[SEL_HI_BIT];
        clr_en = frame && !retain;
        if (wr_en) begin
            dreg_next = cb_data;
        end else if (clr_en) begin
            dreg_next = '0;
        end else begin
            dreg_next = dreg_cur;
        end
        hit_low  = cb_vld && (cb_data[PRESET_W-1:0] == PRESET_LOW_CODE);
        hit_high = cb_vld && (cb_data[PRESET_W-1:0] == PRESET_HIGH_CODE);
    end

endmodule

// File: rtl/diag_field_map.sv
module diag_field_map
    import diag_pkg::*;
(
    input  logic [CB_W-1:0] dreg,
    input  logic            master,
    output logic            dflt,
    output loop_e           loop,
    output logic            fun,
    output logic            swap,
    output logic            dlo,
    output logic            blocked
);

    loop_e req;

    always_comb begin
        req     = loop_e'({dreg[ROUTE_HI_BIT], dreg[ROUTE_LO_BIT]});
        dflt    = &dreg[CB_W-1:NIB_LO];
        loop    = LB_NORMAL;
        fun     = 1'b0;
        swap    = 1'b0;
        dlo     = 1'b0;
        blocked = 1'b0;
        if (!dflt) begin
            unique case (req)
                LB_LINE:   blocked = !master;
                LB_REMOTE: blocked = master;
                default:   blocked = 1'b0;
            endcase
            loop = blocked ? LB_NORMAL : req;
            fun  = dreg[FUN_BIT];
            swap = dreg[SWAP_BIT] && master;
            dlo  = dreg[DLO_BIT];
        end
    end

endmodule

// File: rtl/diag_loop_mux.sv
module diag_loop_mux
    import diag_pkg::*;
#(
    parameter int       LANES      = 1,
    parameter bit       IDLE_LEVEL = 1'b0
) (
    input  loop_e             loop,
    input  logic              dlo,
    input  logic [LANES-1:0]  sys_in,
    input  logic [LANES-1:0]  core_sys_in,
    input  logic [LANES-1:0]  line_in,
    input  logic [LANES-1:0]  core_line_in,
    output logic [LANES-1:0]  sys_out,
    output logic [LANES-1:0]  core_sys_out,
    output logic [LANES-1:0]  core_line_out,
    output logic [LANES-1:0]  line_out
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            sys_out[g]       = (loop == LB_SYS_ECHO) ? sys_in[g]       : core_sys_in[g];
            core_sys_out[g]  = (loop == LB_REMOTE)   ? core_sys_in[g]  : sys_in[g];
            core_line_out[g] = (loop == LB_LINE)     ? core_line_in[g] : line_in[g];
            line_out[g]      = dlo ? IDLE_LEVEL : core_line_in[g];
        end
    end

endmodule

// File: rtl/diag_ctl.sv
module diag_ctl
    import diag_pkg::*;
#(
    parameter int LANES      = 1,
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cb_vld_i,
    input  logic [7:0]        cb_data_i,
    input  logic              frame_i,
    input  logic              retain_i,
    input  logic              master_i,
    input  logic [LANES-1:0]  sys_in_i,
    output logic [LANES-1:0]  sys_out_o,
    input  logic [LANES-1:0]  core_sys_i,
    output logic [LANES-1:0]  core_sys_o,
    input  logic [LANES-1:0]  line_in_i,
    output logic [LANES-1:0]  core_line_o,
    input  logic [LANES-1:0]  core_line_i,
    output logic [LANES-1:0]  line_out_o,
    output logic [7:0]        diag_o,
    output logic              fun_o,
    output logic              swap_o,
    output logic              dlo_o,
    output logic              reject_o,
    output logic              dflt_o,
    output logic [1:0]        preset_o
);

    diag_state_t st_d, st_q;

    logic            wr_en;
    logic [CB_W-1:0] dreg_next;
    logic            hit_low, hit_high;
    logic            dflt_n, fun_n, swap_n, dlo_n, blocked_n;
    loop_e           loop_n;

    diag_wr_dec u_dec (
        .cb_vld    (cb_vld_i),
        .cb_data   (cb_data_i),
        .frame     (frame_i),
        .retain    (retain_i),
        .dreg_cur  (st_q.dreg),
        .wr_en     (wr_en),
        .dreg_next (dreg_next),
        .hit_low   (hit_low),
        .hit_high  (hit_high)
    );

    diag_field_map u_map (
        .dreg    (dreg_next),
        .master  (master_i),
        .dflt    (dflt_n),
        .loop    (loop_n),
        .fun     (fun_n),
        .swap    (swap_n),
        .dlo     (dlo_n),
        .blocked (blocked_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.dreg   = dreg_next;
        st_d.dflt   = dflt_n;
        st_d.loop   = loop_n;
        st_d.fun    = fun_n;
        st_d.swap   = swap_n;
        st_d.dlo    = dlo_n;
        st_d.reject = st_q.reject | blocked_n;
        if (!dflt_n) begin
            st_d.preset = PRE_NONE;
        end else if (hit_low) begin
            st_d.preset = PRE_LOW;
        end else if (hit_high) begin
            st_d.preset = PRE_HIGH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    diag_loop_mux #(
        .LANES      (LANES),
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_mux (
        .loop          (st_q.loop),
        .dlo           (st_q.dlo),
        .sys_in        (sys_in_i),
        .core_sys_in   (core_sys_i),
        .line_in       (line_in_i),
        .core_line_in  (core_line_i),
        .sys_out       (sys_out_o),
        .core_sys_out  (core_sys_o),
        .core_line_out (core_line_o),
        .line_out      (line_out_o)
    );

    assign diag_o   = {1'b0, st_q.dreg[RSV_BIT-1:0]};
    assign fun_o    = st_q.fun;
    assign swap_o   = st_q.swap;
    assign dlo_o    = st_q.dlo;
    assign reject_o = st_q.reject;
    assign dflt_o   = st_q.dflt;
    assign preset_o = st_q.preset;

endmodule

// File: rtl/diag_ctl_chk.sv
module diag_ctl_chk #(
    parameter int LANES      = 1,
    parameter bit IDLE_LEVEL = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cb_vld_i,
    input logic [7:0]       cb_data_i,
    input logic             frame_i,
    input logic             retain_i,
    input logic             master_i,
    input logic [LANES-1:0] line_out_o,
    input logic [7:0]       diag_o,
    input logic             fun_o,
    input logic             swap_o,
    input logic             dlo_o,
    input logic             reject_o,
    input logic             dflt_o,
    input logic [1:0]       preset_o
);

    logic wr_seen, clr_seen;
    assign wr_seen  = cb_vld_i && (cb_data_i[1:0] == 2'b10);
    assign clr_seen = frame_i && !retain_i;

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |=> diag_o[6:0] == $past(cb_data_i[6:0]));

    p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_seen && !clr_seen) |=> $stable(diag_o));

    p_swap_role_r4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> $past(master_i));

    p_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dlo_o |-> line_out_o == {LANES{IDLE_LEVEL}});

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_seen && !wr_seen) |=> diag_o == 8'h00);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_seen && wr_seen) |=> diag_o[6:0] == $past(cb_data_i[6:0]));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> reject_o);

    p_dflt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_o |-> !(fun_o || swap_o || dlo_o));

    p_preset_dflt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_o != 2'b00) |-> dflt_o);

    p_bit7_r10: assert property (@(posedge clk) disable iff (!rst_n)
        diag_o[7] == 1'b0);

endmodule

bind diag_ctl diag_ctl_chk #(
    .LANES      (LANES),
    .IDLE_LEVEL (IDLE_LEVEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cb_vld_i   (cb_vld_i),
    .cb_data_i  (cb_data_i),
    .frame_i    (frame_i),
    .retain_i   (retain_i),
    .master_i   (master_i),
    .line_out_o (line_out_o),
    .diag_o     (diag_o),
    .fun_o      (fun_o),
    .swap_o     (swap_o),
    .dlo_o      (dlo_o),
    .reject_o   (reject_o),
    .dflt_o     (dflt_o),
    .preset_o   (preset_o)
);

// File: tb/diag_ctl_bench.sv
module diag_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 2;
    localparam bit IDLE       = 1'b1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld = 1'b0;
    logic [7:0]   cb = 8'h00;
    logic         fr = 1'b0;
    logic         ret = 1'b1;
    logic         mas = 1'b0;
    logic [L-1:0] sys_in = '0, core_sys_in = '0, line_in = '0, core_line_in = '0;
    logic [L-1:0] sys_out, core_sys_out, core_line_out, line_out;
    logic [7:0]   diag;
    logic         fun, swap, dlo, rej, dflt;
    logic [1:0]   preset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    diag_ctl #(.LANES(L), .IDLE_LEVEL(IDLE)) u_diag_ctl (
        .clk(clk), .rst_n(rst_n), .cb_vld_i(vld), .cb_data_i(cb),
        .frame_i(fr), .retain_i(ret), .master_i(mas),
        .sys_in_i(sys_in), .sys_out_o(sys_out),
        .core_sys_i(core_sys_in), .core_sys_o(core_sys_out),
        .line_in_i(line_in), .core_line_o(core_line_out),
        .core_line_i(core_line_in), .line_out_o(line_out),
        .diag_o(diag), .fun_o(fun), .swap_o(swap), .dlo_o(dlo),
        .reject_o(rej), .dflt_o(dflt), .preset_o(preset)
    );

    // behavioural reference state
    int m_reg, m_pre;
    bit m_dflt, m_echo, m_lline, m_remote, m_fun, m_swap, m_dlo, m_rej;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 0; m_pre = 0; m_dflt = 0; m_echo = 0; m_lline = 0;
            m_remote = 0; m_fun = 0; m_swap = 0; m_dlo = 0; m_rej = 0;
        end else begin
            bit want_echo, want_line, want_remote, refused;
            if (vld && cb[0] == 1'b0 && cb[1] == 1'b1) m_reg = int'(cb);
            else if (fr && !ret) m_reg = 0;
            m_dflt = (m_reg / 16) == 15;
            if (!m_dflt) m_pre = 0;
            else if (vld && (cb % 32) == 15) m_pre = 1;
            else if (vld && (cb % 32) == 31) m_pre = 2;
            want_echo   = ((m_reg / 4) % 4) == 2;
            want_line   = ((m_reg / 4) % 4) == 1;
            want_remote = ((m_reg / 4) % 4) == 3;
            if (m_dflt) begin
                m_echo = 0; m_lline = 0; m_remote = 0;
                m_fun = 0; m_swap = 0; m_dlo = 0;
            end else begin
                refused  = (want_line && !mas) || (want_remote && mas);
                m_rej    = m_rej || refused;
                m_echo   = want_echo;
                m_lline  = want_line && mas;
                m_remote = want_remote && !mas;
                m_fun    = ((m_reg / 16) % 2) == 1;
                m_swap   = (((m_reg / 32) % 2) == 1) && mas;
                m_dlo    = ((m_reg / 64) % 2) == 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [L-1:0] e_so, e_cs, e_cl, e_lo;
        e_so = m_echo   ? sys_in       : core_sys_in;
        e_cs = m_remote ? core_sys_in  : sys_in;
        e_cl = m_lline  ? core_line_in : line_in;
        e_lo = m_dlo    ? {L{IDLE}}    : core_line_in;
        chk(diag == 8'(m_reg % 128), "R1 diag word", int'(diag), m_reg % 128);
        chk(diag[7] == 1'b0, "R10 bit7 readback", int'(diag[7]), 0);
        chk({sys_out, core_sys_out, core_line_out} == {e_so, e_cs, e_cl}, "R2 routing",
            int'({sys_out, core_sys_out, core_line_out}), int'({e_so, e_cs, e_cl}));
        chk(fun == m_fun, "R3 force unsync", int'(fun), int'(m_fun));
        chk(swap == m_swap, "R4 poly swap", int'(swap), int'(m_swap));
        chk(dlo == m_dlo && line_out == e_lo, "R5 line idle", int'({dlo, line_out}), int'({m_dlo, e_lo}));
        chk(rej == m_rej, "R8 reject flag", int'(rej), int'(m_rej));
        chk(dflt == m_dflt && int'(preset) == m_pre, "R9 default mode",
            int'({dflt, preset}), int'(m_dflt) * 4 + m_pre);
    endtask

    // drive one cycle of stimulus at the falling edge, then compare
    task automatic step(input bit v, input logic [7:0] b, input bit f, input bit r, input bit m);
        @(negedge clk);
        vld = v; cb = b; fr = f; ret = r; mas = m;
        sys_in = L'($urandom); core_sys_in = L'($urandom);
        line_in = L'($urandom); core_line_in = L'($urandom);
        #1;
        compare();
    endtask

    task automatic idle(input int n, input bit r, input bit m);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, r, m);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        #1;
        chk({diag, fun, swap, dlo, rej, dflt, preset} == '0, "R12 reset state",
            int'({fun, swap, dlo, rej, dflt, preset}), 0);
        compare();
        @(negedge clk);
        rst_n = 1'b1;

        // R1 plain write, then ignored select patterns
        step(1, 8'h02, 0, 1, 1);
        idle(2, 1, 1);
        step(1, 8'h53, 0, 1, 1);
        step(1, 8'h51, 0, 1, 1);
        step(1, 8'h50, 0, 1, 1);
        idle(1, 1, 1);
        chk(diag == 8'h02, "R1 ignored selects keep word", int'(diag), 8'h02);

        // R2 system echo in both roles
        step(1, 8'h0A, 0, 1, 1);
        idle(4, 1, 1);
        idle(4, 1, 0);
        // line loop allowed in master, remote allowed in slave
        step(1, 8'h06, 0, 1, 1);
        idle(4, 1, 1);
        step(1, 8'h0E, 0, 1, 0);
        idle(4, 1, 0);
        chk(rej == 1'b0, "R8 no reject for legal routes", int'(rej), 0);

        // R3 R4 R5 individual bits, swap gated by role
        step(1, 8'h12, 0, 1, 1);
        idle(2, 1, 1);
        step(1, 8'h22, 0, 1, 1);
        idle(2, 1, 1);
        idle(2, 1, 0);
        chk(swap == 1'b0, "R4 swap off in slave", int'(swap), 0);
        step(1, 8'h42, 0, 1, 1);
        idle(3, 1, 1);
        chk(line_out == {L{IDLE}}, "R5 line held idle", int'(line_out), int'({L{IDLE}}));

        // R10 bit 7 only
        step(1, 8'h82, 0, 1, 1);
        idle(2, 1, 1);
        chk(diag == 8'h02 && !fun && !swap && !dlo, "R10 bit7 no effect", int'(diag), 8'h02);

        // R8 refused routes
        step(1, 8'h06, 0, 1, 0);
        idle(2, 1, 0);
        chk(rej == 1'b1, "R8 line loop refused in slave", int'(rej), 1);
        step(1, 8'h02, 0, 1, 0);
        idle(2, 1, 0);
        chk(rej == 1'b1, "R8 reject stays set", int'(rej), 1);
        step(1, 8'h0E, 0, 1, 1);
        idle(2, 1, 1);

        // R6 frame clear and retain
        step(1, 8'h16, 0, 0, 1);
        step(0, 8'h00, 1, 1, 1);
        idle(1, 1, 1);
        chk(diag == 8'h16, "R6 retained across frame", int'(diag), 8'h16);
        step(0, 8'h00, 1, 0, 1);
        idle(1, 0, 1);
        chk(diag == 8'h00, "R6 cleared at frame", int'(diag), 0);

        // R11: value must not appear before the storing edge
        @(negedge clk);
        vld = 1'b1; cb = 8'h12; fr = 1'b0; ret = 1'b1; mas = 1'b1;
        #1;
        chk(diag == 8'h00 && !fun, "R11 no change before edge", int'(diag), 0);
        @(posedge clk);
        #1;
        chk(diag == 8'h12 && fun, "R11 change at edge", int'(diag), 8'h12);

        // R7 write wins over clear in the same cycle
        step(1, 8'h26, 1, 0, 1);
        idle(1, 0, 1);
        chk(diag == 8'h26, "R7 write beats clear", int'(diag), 8'h26);

        // R9 default mode and presets
        step(1, 8'hF2, 0, 1, 1);
        idle(1, 1, 1);
        chk(dflt && preset == 2'b00, "R9 default without preset", int'({dflt, preset}), 4);
        step(1, 8'h0F, 0, 1, 1);
        idle(1, 1, 1);
        chk(preset == 2'b01, "R9 low preset", int'(preset), 1);
        step(1, 8'hFF, 0, 1, 0);
        idle(1, 1, 0);
        chk(preset == 2'b10, "R9 high preset", int'(preset), 2);
        step(1, 8'hFE, 0, 1, 1);
        idle(2, 1, 1);
        step(1, 8'h02, 0, 1, 1);
        idle(1, 1, 1);
        chk(!dflt && preset == 2'b00, "R9 leave default", int'({dflt, preset}), 0);

        // random traffic compared every cycle
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] rb;
            rb = 8'($urandom);
            if (($urandom % 4) == 0) rb[7:4] = 4'hF;
            step(($urandom % 3) != 0, rb, ($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0);
        end

        // R12 reset clears sticky flag
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(rej == 1'b0 && diag == 8'h00, "R12 reset clears", int'({rej, diag}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, 1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule